// File: doc/BRIEF.md
# Priority-Inheriting Lock Manager

This block arbitrates a single shared resource among a small group of prioritized tasks. Each task drives a one-cycle acquire or release pulse together with its base priority. The block decides ownership in one registered step, the same way a test-and-set would, so two tasks can never both hold the lock. A task that asks while the lock is taken is parked in a waiting set. On release, the lock passes straight to the most urgent waiter.

Alongside the lock state, the block publishes an effective priority for every task, for use by an external scheduler. A non-owner's effective priority is its base priority. The owner's effective priority is lifted to the highest base priority among the waiters. This keeps a low-priority owner from stalling a more urgent task. The lift disappears as soon as the owner lets go. A release pulse from a task that does not own the lock changes nothing, and the block flags it with a one-cycle error strobe.

Top module: `pi_mutex`

## Requirements
- R1: When the lock is free, the acquiring task with the largest base priority wins. Ties go to the lowest task index. The winner sees a single-cycle `grant_o` pulse in the cycle after its acquire, and `lock_held_o`/`owner_id_o` show it from that cycle on. At most one `grant_o` bit is ever high.
- R2: An acquire from a task other than the owner, while the lock is held, sets that task's `wait_o` bit in the next cycle. No grant is given and the owner does not change.
- R3: A waiting task that pulses acquire again leaves `wait_o` unchanged, so it is served once. An acquire from the current owner is ignored.
- R4: While the lock is held, the owner's effective priority equals the larger of its own base priority and the largest base priority in the waiting set. Every other task's effective priority equals its base priority. The outputs reflect each acquire or release in the cycle after it.
- R5: The cycle after the owner releases, the former owner's effective priority is back to its base value.
- R6: A release by the owner hands the lock to the highest-priority waiter (ties to the lowest index), with a grant pulse in the next cycle, and removes that task from `wait_o`. With no waiters, the lock becomes free.
- R7: A release from a task that does not own the lock, including any release while the lock is free, leaves the owner and the waiting set unchanged. It raises `rel_err_o` for exactly the next cycle.
- R8: While `rst_n` is low, the lock is free, `wait_o`, `grant_o` and `rel_err_o` are zero, and all effective priorities are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acq_i | input | 8 | Acquire pulse, one bit per task |
| rel_i | input | 8 | Release pulse, one bit per task |
| base_prio_i | input | 32 | Base priority of task i at bits [4*i+3:4*i]; a larger value is more urgent |
| grant_o | output | 8 | One-cycle pulse to the task that just became owner |
| wait_o | output | 8 | Set of tasks blocked on the lock |
| lock_held_o | output | 1 | Lock is owned |
| owner_id_o | output | 3 | Index of the owner, meaningful while `lock_held_o` is high |
| eff_prio_o | output | 32 | Effective priority of task i at bits [4*i+3:4*i] |
| rel_err_o | output | 1 | One-cycle strobe after a release from a non-owner |

## Verification
The owner's release and new acquire requests from other tasks can arrive in the same cycle. When they do, the handover must choose among the old waiters and the fresh requesters together, and the owner's priority lift must drop in that same step. A stray release from a non-owner can also coincide with a valid one. The random phase provokes both overlaps often: it pulses several acquire bits at once, has the owner release while others request, and sometimes sets release bits on tasks that do not own the lock. Every cycle is judged against a bench model of the lock state and the effective priorities, derived from the requirements.

// File: rtl/mtx_pkg.sv
// Package mtx_pkg
// Shared defaults for the lock manager: task count and priority width.
// Assumes every module takes these as parameter defaults only.
package mtx_pkg;
    parameter int unsigned DEF_TASKS  = 8;
    parameter int unsigned DEF_PRIO_W = 4;
endpackage

// File: rtl/mtx_pick.sv
// Module mtx_pick
// Combinational selector: from a mask of candidate tasks, returns the one
// with the largest priority (lowest index on a tie) and that priority.
// Assumes prio_i packs task i at bits [i*PRIO_W +: PRIO_W].
module mtx_pick #(
    parameter int unsigned N_TASKS = mtx_pkg::DEF_TASKS,
    parameter int unsigned PRIO_W  = mtx_pkg::DEF_PRIO_W,
    localparam int unsigned IDW    = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
    input  logic [N_TASKS-1:0]        mask_i,
    input  logic [N_TASKS*PRIO_W-1:0] prio_i,
    output logic                      found_o,
    output logic [IDW-1:0]            idx_o,
    output logic [PRIO_W-1:0]         prio_o
);
    // Linear scan; strict compare keeps the lowest index on equal priority.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = 0; i < N_TASKS; i++) begin
            if (mask_i[i] && (!found_o || prio_i[i*PRIO_W +: PRIO_W] > prio_o)) begin
                found_o = 1'b1;
                idx_o   = IDW'(i);
                prio_o  = prio_i[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/mtx_lock_state.sv
// Module mtx_lock_state
// Holds owner, held flag and waiting set, and computes the next state.
// A release from the owner and new acquires in the same cycle are merged
// into one handover. Also yields the next owner and next top waiter
// priority so the priority stage can register them in step.
// Assumes acquire and release are one-cycle pulses per task.
module mtx_lock_state #(
    parameter int unsigned N_TASKS = mtx_pkg::DEF_TASKS,
    parameter int unsigned PRIO_W  = mtx_pkg::DEF_PRIO_W,
    localparam int unsigned IDW    = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_TASKS-1:0]        acq_i,
    input  logic [N_TASKS-1:0]        rel_i,
    input  logic [N_TASKS*PRIO_W-1:0] base_prio_i,
    output logic                      held_o,
    output logic [IDW-1:0]            owner_o,
    output logic [N_TASKS-1:0]        wait_o,
    output logic [N_TASKS-1:0]        grant_o,
    output logic                      rel_err_o,
    output logic                      held_n_o,
    output logic [IDW-1:0]            owner_n_o,
    output logic                      wtop_found_n_o,
    output logic [PRIO_W-1:0]         wtop_prio_n_o
);
    logic [N_TASKS-1:0] own_mask;
    logic [N_TASKS-1:0] cand;
    logic [N_TASKS-1:0] wait_n;
    logic [N_TASKS-1:0] grant_n;
    logic               rel_ok;
    logic               pick_found;
    logic [IDW-1:0]     pick_idx;
    logic [PRIO_W-1:0]  pick_prio;
    logic [IDW-1:0]     wtop_idx;

    // One-hot of the owner, empty when the lock is free.
    always_comb begin
        own_mask = '0;
        if (held_o) own_mask[owner_o] = 1'b1;
    end

    assign rel_ok = |(rel_i & own_mask);
    // Owner acquires are dropped; old waiters join fresh requesters.
    assign cand   = wait_o | (acq_i & ~own_mask);

    mtx_pick #(.N_TASKS(N_TASKS), .PRIO_W(PRIO_W)) u_pick_owner (
        .mask_i  (cand),
        .prio_i  (base_prio_i),
        .found_o (pick_found),
        .idx_o   (pick_idx),
        .prio_o  (pick_prio)
    );

    // Next-state decision: keep the owner, or hand over to the best candidate.
    always_comb begin
        held_n_o  = held_o;
        owner_n_o = owner_o;
        wait_n    = cand;
        grant_n   = '0;
        if (!held_o || rel_ok) begin
            held_n_o = pick_found;
            if (pick_found) begin
                owner_n_o         = pick_idx;
                grant_n[pick_idx] = 1'b1;
                wait_n[pick_idx]  = 1'b0;
            end
        end
    end

    mtx_pick #(.N_TASKS(N_TASKS), .PRIO_W(PRIO_W)) u_pick_waiter (
        .mask_i  (wait_n),
        .prio_i  (base_prio_i),
        .found_o (wtop_found_n_o),
        .idx_o   (wtop_idx),
        .prio_o  (wtop_prio_n_o)
    );

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_o    <= 1'b0;
            owner_o   <= '0;
            wait_o    <= '0;
            grant_o   <= '0;
            rel_err_o <= 1'b0;
        end else begin
            held_o    <= held_n_o;
            owner_o   <= owner_n_o;
            wait_o    <= wait_n;
            grant_o   <= grant_n;
            rel_err_o <= |(rel_i & ~own_mask);
        end
    end

    logic unused_ok;
    assign unused_ok = &{1'b0, pick_prio, wtop_idx};
endmodule

// File: rtl/mtx_eff_prio.sv
// Module mtx_eff_prio
// Registers the effective priority per task: base priority, except that
// the next owner takes the higher of its base and the top waiter priority.
// Assumes next-state owner and waiter data come from mtx_lock_state.
module mtx_eff_prio #(
    parameter int unsigned N_TASKS = mtx_pkg::DEF_TASKS,
    parameter int unsigned PRIO_W  = mtx_pkg::DEF_PRIO_W,
    localparam int unsigned IDW    = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_TASKS*PRIO_W-1:0] base_prio_i,
    input  logic                      held_n_i,
    input  logic [IDW-1:0]            owner_n_i,
    input  logic                      wtop_found_n_i,
    input  logic [PRIO_W-1:0]         wtop_prio_n_i,
    output logic [N_TASKS*PRIO_W-1:0] eff_prio_o
);
    for (genvar g = 0; g < N_TASKS; g++) begin : g_task
        logic [PRIO_W-1:0] base;
        logic [PRIO_W-1:0] eff_n;
        logic              is_owner;
        assign base     = base_prio_i[g*PRIO_W +: PRIO_W];
        assign is_owner = held_n_i && (owner_n_i == IDW'(g));

        // Lift the owner to the top waiter priority when that is higher.
        always_comb begin
            eff_n = base;
            if (is_owner && wtop_found_n_i && wtop_prio_n_i > base)
                eff_n = wtop_prio_n_i;
        end

        // Per-task output register.
        always_ff @(posedge clk) begin
            if (!rst_n) eff_prio_o[g*PRIO_W +: PRIO_W] <= '0;
            else        eff_prio_o[g*PRIO_W +: PRIO_W] <= eff_n;
        end
    end
endmodule

// File: rtl/pi_mutex.sv
// Module pi_mutex (top)
// Single-resource lock with priority inheritance for N_TASKS tasks.
// Assumes per-task one-cycle acquire/release pulses and base priorities
// that are stable while they matter; larger priority value is more urgent.
module pi_mutex #(
    parameter int unsigned N_TASKS = mtx_pkg::DEF_TASKS,
    parameter int unsigned PRIO_W  = mtx_pkg::DEF_PRIO_W,
    localparam int unsigned IDW    = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_TASKS-1:0]        acq_i,
    input  logic [N_TASKS-1:0]        rel_i,
    input  logic [N_TASKS*PRIO_W-1:0] base_prio_i,
    output logic [N_TASKS-1:0]        grant_o,
    output logic [N_TASKS-1:0]        wait_o,
    output logic                      lock_held_o,
    output logic [IDW-1:0]            owner_id_o,
    output logic [N_TASKS*PRIO_W-1:0] eff_prio_o,
    output logic                      rel_err_o
);
    logic              held_n;
    logic [IDW-1:0]    owner_n;
    logic              wtop_found_n;
    logic [PRIO_W-1:0] wtop_prio_n;

    mtx_lock_state #(.N_TASKS(N_TASKS), .PRIO_W(PRIO_W)) u_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .acq_i          (acq_i),
        .rel_i          (rel_i),
        .base_prio_i    (base_prio_i),
        .held_o         (lock_held_o),
        .owner_o        (owner_id_o),
        .wait_o         (wait_o),
        .grant_o        (grant_o),
        .rel_err_o      (rel_err_o),
        .held_n_o       (held_n),
        .owner_n_o      (owner_n),
        .wtop_found_n_o (wtop_found_n),
        .wtop_prio_n_o  (wtop_prio_n)
    );

    mtx_eff_prio #(.N_TASKS(N_TASKS), .PRIO_W(PRIO_W)) u_eff (
        .clk            (clk),
        .rst_n          (rst_n),
        .base_prio_i    (base_prio_i),
        .held_n_i       (held_n),
        .owner_n_i      (owner_n),
        .wtop_found_n_i (wtop_found_n),
        .wtop_prio_n_i  (wtop_prio_n),
        .eff_prio_o     (eff_prio_o)
    );
endmodule

// File: rtl/mtx_checker.sv
// Module mtx_checker
// Temporal properties on the lock manager ports; bound into pi_mutex.
module mtx_checker #(
    parameter int unsigned N_TASKS = mtx_pkg::DEF_TASKS,
    parameter int unsigned PRIO_W  = mtx_pkg::DEF_PRIO_W,
    localparam int unsigned IDW    = (N_TASKS > 1) ? $clog2(N_TASKS) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [N_TASKS-1:0]        acq_i,
    input logic [N_TASKS-1:0]        rel_i,
    input logic [N_TASKS-1:0]        grant_o,
    input logic [N_TASKS-1:0]        wait_o,
    input logic                      lock_held_o,
    input logic [IDW-1:0]            owner_id_o,
    input logic                      rel_err_o
);
    p_one_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    p_grant_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant_o) |-> (lock_held_o && grant_o[owner_id_o]));

    p_owner_not_waiting_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_held_o |-> !wait_o[owner_id_o]);

    p_owner_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_held_o && !rel_i[owner_id_o]) |=> (lock_held_o && $stable(owner_id_o) && grant_o == '0));

    p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_err_o |-> $past(rel_i != '0));

    logic unused_ok;
    assign unused_ok = &{1'b0, acq_i};
endmodule

bind pi_mutex mtx_checker #(.N_TASKS(N_TASKS), .PRIO_W(PRIO_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_i       (acq_i),
    .rel_i       (rel_i),
    .grant_o     (grant_o),
    .wait_o      (wait_o),
    .lock_held_o (lock_held_o),
    .owner_id_o  (owner_id_o),
    .rel_err_o   (rel_err_o)
);

// File: tb/sim_pi_mutex.sv
`timescale 1ns/1ps
module sim_pi_mutex;
    localparam int NT = 8;
    localparam int PW = 4;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NT-1:0]   acq_i, rel_i;
    logic [NT*PW-1:0] base_prio_i;
    logic [NT-1:0]   grant_o, wait_o;
    logic            lock_held_o;
    logic [2:0]      owner_id_o;
    logic [NT*PW-1:0] eff_prio_o;
    logic            rel_err_o;

    logic [PW-1:0] bp [NT];
    always_comb for (int i = 0; i < NT; i++) base_prio_i[i*PW +: PW] = bp[i];

    always #2.5 clk = ~clk;

    pi_mutex u0 (.*);

    int n_checks = 0;
    int n_errors = 0;

    // Expected state built from the requirements.
    logic          m_held;
    int            m_owner;
    logic [NT-1:0] m_wait, m_grant;
    logic          m_err;
    logic [PW-1:0] m_eff [NT];

    task automatic chk(bit ok, string tag, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int eff_of(int i);
        return int'(eff_prio_o[i*PW +: PW]);
    endfunction

    task automatic model_step(logic [NT-1:0] a, logic [NT-1:0] r);
        logic [NT-1:0] own, cand;
        logic rel_ok;
        int best;
        own = m_held ? NT'(1) << m_owner : '0;
        m_err = |(r & ~own);
        rel_ok = m_held && r[m_owner];
        cand = m_wait | (a & ~own);
        m_grant = '0;
        if (m_held && !rel_ok) m_wait = cand;
        else begin
            best = -1;
            for (int i = 0; i < NT; i++)
                if (cand[i] && (best < 0 || bp[i] > bp[best])) best = i;
            if (best >= 0) begin
                m_held = 1'b1; m_owner = best; m_grant[best] = 1'b1;
                m_wait = cand & ~(NT'(1) << best);
            end else begin
                m_held = 1'b0; m_wait = '0;
            end
        end
        for (int i = 0; i < NT; i++) m_eff[i] = bp[i];
        if (m_held)
            for (int i = 0; i < NT; i++)
                if (m_wait[i] && bp[i] > m_eff[m_owner]) m_eff[m_owner] = bp[i];
    endtask

    task automatic compare_all(string tag);
        chk(lock_held_o == m_held, {tag, " R1 R6 held"}, lock_held_o, m_held);
        if (m_held) chk(int'(owner_id_o) == m_owner, {tag, " R1 R6 owner"}, owner_id_o, m_owner);
        chk(wait_o == m_wait, {tag, " R2 R3 wait"}, wait_o, m_wait);
        chk(grant_o == m_grant, {tag, " R1 grant"}, grant_o, m_grant);
        chk(rel_err_o == m_err, {tag, " R7 err"}, rel_err_o, m_err);
        for (int i = 0; i < NT; i++)
            chk(eff_of(i) == int'(m_eff[i]), {tag, " R4 R5 eff"}, eff_of(i), m_eff[i]);
    endtask

    // Drive one cycle of pulses, step the model, sample after the edge.
    task automatic cycle(logic [NT-1:0] a, logic [NT-1:0] r, string tag);
        @(negedge clk);
        acq_i = a; rel_i = r;
        model_step(a, r);
        @(posedge clk); #1;
        compare_all(tag);
        @(negedge clk);
        acq_i = '0; rel_i = '0;
    endtask

    initial begin : watchdog
        #500us;
        n_checks++; n_errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd1234));
        acq_i = '0; rel_i = '0; rst_n = 1'b0;
        bp = '{4'd2, 4'd5, 4'd5, 4'd9, 4'd1, 4'd12, 4'd3, 4'd7};
        m_held = 0; m_owner = 0; m_wait = '0; m_grant = '0; m_err = 0;
        for (int i = 0; i < NT; i++) m_eff[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        chk(!lock_held_o && wait_o == 0 && grant_o == 0 && !rel_err_o, "R8 reset outputs", lock_held_o, 0);
        chk(eff_prio_o == 0, "R8 reset eff", int'(eff_prio_o[15:0]), 0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        model_step('0, '0);

        // Directed corner cases
        cycle(8'h01, 8'h00, "d_acq_t0");
        chk(lock_held_o && owner_id_o == 0 && grant_o == 8'h01, "R1 single grant t0", owner_id_o, 0);
        cycle(8'h08, 8'h00, "d_wait_t3");
        chk(wait_o == 8'h08 && eff_of(0) == 9, "R4 owner lifted to 9", eff_of(0), 9);
        cycle(8'h09, 8'h00, "d_reacq");
        chk(wait_o == 8'h08 && grant_o == 0, "R3 no duplicate entry", wait_o, 8);
        cycle(8'h00, 8'h20, "d_bad_rel");
        chk(rel_err_o && owner_id_o == 0 && wait_o == 8'h08, "R7 stray release ignored", rel_err_o, 1);
        @(posedge clk); #1;
        chk(!rel_err_o, "R7 strobe one cycle", rel_err_o, 0);
        cycle(8'h00, 8'h01, "d_handover");
        chk(owner_id_o == 3 && grant_o == 8'h08 && eff_of(0) == 2, "R5 R6 handover to t3, t0 back to 2", eff_of(0), 2);
        cycle(8'h00, 8'h08, "d_free");
        chk(!lock_held_o, "R6 lock free without waiters", lock_held_o, 0);
        cycle(8'h16, 8'h00, "d_tie");
        chk(owner_id_o == 1 && wait_o == 8'h14, "R1 tie goes to lowest index", owner_id_o, 1);
        cycle(8'h00, 8'h02, "d_rel1");
        chk(owner_id_o == 2, "R6 equal waiter takes over", owner_id_o, 2);
        cycle(8'h80, 8'h04, "d_rel_and_acq");
        chk(owner_id_o == 7 && wait_o == 8'h10, "R6 fresh requester beats old waiter", owner_id_o, 7);
        cycle(8'h00, 8'h80, "d_rel7");
        cycle(8'h00, 8'h10, "d_rel4");
        chk(!lock_held_o, "R6 drained", lock_held_o, 0);

        // Constrained random phase
        for (int c = 0; c < 4000; c++) begin
            logic [NT-1:0] a, r;
            if (c % 500 == 0) begin
                @(negedge clk);
                for (int i = 0; i < NT; i++) bp[i] = PW'($urandom_range(0, 15));
                model_step('0, '0);
                @(posedge clk); #1;
            end
            a = '0; r = '0;
            for (int i = 0; i < NT; i++) if ($urandom_range(0, 7) == 0) a[i] = 1'b1;
            if (m_held && $urandom_range(0, 3) == 0) r[m_owner] = 1'b1;
            if ($urandom_range(0, 15) == 0) r[$urandom_range(0, NT-1)] = 1'b1;
            cycle(a, r, "rand");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule